// File: doc/BRIEF.md
# Fixed Off-Time Mixed-Decay Chopper

This block limits peak load current in a full-bridge drive. A comparator outside the block reports when the amplified sense voltage exceeds the reference. The block synchronizes that signal and, while the bridge is driving, turns an accepted trip into a chop request. The request tells the bridge controller to switch off the source drive for a fixed off-time. During the off-time the block also selects the decay style. First comes a dead interval. Then fast decay runs for a fixed 13 % share of the programmed off period, and slow decay fills the rest.

Switching transients would make the comparator fire falsely. The block therefore ignores it for a blanking window after every switching event. That covers the return from an internal chop and either edge of the externally applied PWM enable. In brake mode no current flows through the sense path, so the block stays idle.

All times are parameters counted in clock cycles. The analog comparator and the RC timing network are not part of this block.

Top module: `offtime_chopper`

## Requirements
- R1: After reset `chopOut` and `fastDecay` are both low.
- R2: A trip is accepted only after two synchronizing flops. With the bridge driving and no blanking, `chopOut` rises after the third rising clock edge that samples `tripIn` high.
- R3: Once raised, `chopOut` stays high for exactly DEAD_CYCLES + OFF_CYCLES cycles and then returns low.
- R4: Within the off-time, `fastDecay` is low for the first DEAD_CYCLES cycles. It is then high for FAST = max(1, floor(13 × OFF_CYCLES / 100)) cycles, and low (slow decay) for the remaining OFF_CYCLES − FAST cycles.
- R5: When the off-time ends, a blank of BLANK_CYCLES cycles starts. A comparator input held high re-trips only once that blank has run out.
- R6: Either edge of `driveEn` starts a blank of BLANK_CYCLES cycles. A trip that is already synchronized in the cycle of the edge is not accepted.
- R7: Comparator activity during the off-time neither extends nor restarts it.
- R8: While `brakeMode` is high, `chopOut` is low on the next cycle: a running off-time is abandoned and no trip is accepted.
- R9: While `driveEn` is low, no trip is accepted.
- R10: `fastDecay` is high only while `chopOut` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tripIn | input | 1 | Over-current comparator output, asynchronous, high = sense above reference |
| driveEn | input | 1 | External PWM enable, synchronous, high = bridge driving |
| brakeMode | input | 1 | High = brake (both low sides on); chopper idle |
| chopOut | output | 1 | High = source drive off (off-time active) |
| fastDecay | output | 1 | High = fast-decay phase, low = slow decay or dead interval |

## Verification
Two events can land on the same clock edge: an external enable edge, and a comparator trip that has already passed through the synchronizer. To provoke this, the bench raises the comparator while the enable is low, so the trip reaches the second flop first, and then raises the enable. The design is correct if it does not chop on that edge and instead waits the full blank that the edge starts. The bench checks this by sampling `chopOut` one cycle before and at the cycle the blank expires.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    PH_DRIVE = 2'd0,
    PH_DEAD  = 2'd1,
    PH_FAST  = 2'd2,
    PH_SLOW  = 2'd3
  } phase_t;

  // control -> datapath strobes
  typedef struct packed {
    logic   cntLoad;
    phase_t loadPhase;
    logic   blankStart;
  } ctrl_strobe_t;

  // datapath -> control status
  typedef struct packed {
    logic tripSeen;
    logic blankBusy;
    logic enEdge;
    logic cntDone;
  } dp_status_t;

  function automatic int fast_len(input int offCycles);
    int v;
    v = (13 * offCycles) / 100;
    return (v < 1) ? 1 : v;
  endfunction

endpackage

// File: rtl/chop_dp.sv
module chop_dp
  import chop_pkg::*;
#(
  parameter int OFF_CYCLES   = 40,
  parameter int DEAD_CYCLES  = 2,
  parameter int BLANK_CYCLES = 6
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tripIn,
  input  logic         driveEn,
  input  ctrl_strobe_t strobe,
  output dp_status_t   status
);

  localparam int FAST_CYCLES = fast_len(OFF_CYCLES);
  localparam int SLOW_CYCLES = OFF_CYCLES - FAST_CYCLES;
  localparam int MAX_PHASE   = (OFF_CYCLES > DEAD_CYCLES) ? OFF_CYCLES : DEAD_CYCLES;
  localparam int CNT_W       = $clog2(MAX_PHASE + 1);
  localparam int BLANK_W     = $clog2(BLANK_CYCLES + 1);

  localparam logic [CNT_W-1:0]   DEAD_LOAD  = CNT_W'(DEAD_CYCLES - 1);
  localparam logic [CNT_W-1:0]   FAST_LOAD  = CNT_W'(FAST_CYCLES - 1);
  localparam logic [CNT_W-1:0]   SLOW_LOAD  = CNT_W'(SLOW_CYCLES - 1);
  localparam logic [BLANK_W-1:0] BLANK_LOAD = BLANK_W'(BLANK_CYCLES);

  logic [1:0]         syncQ;
  logic               prevEn;
  logic               enEdge;
  logic [CNT_W-1:0]   phaseCnt;
  logic [BLANK_W-1:0] blankCnt;
  logic [CNT_W-1:0]   loadVal;

  // two-flop synchronizer for the comparator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b00;
    else       syncQ <= {syncQ[0], tripIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevEn <= 1'b0;
    else       prevEn <= driveEn;
  end

  assign enEdge = driveEn ^ prevEn;

  always_comb begin
    unique case (strobe.loadPhase)
      PH_DEAD: loadVal = DEAD_LOAD;
      PH_FAST: loadVal = FAST_LOAD;
      PH_SLOW: loadVal = SLOW_LOAD;
      default: loadVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 phaseCnt <= '0;
    else if (strobe.cntLoad)   phaseCnt <= loadVal;
    else if (phaseCnt != '0)   phaseCnt <= phaseCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            blankCnt <= '0;
    else if (strobe.blankStart || enEdge) blankCnt <= BLANK_LOAD;
    else if (blankCnt != '0)              blankCnt <= blankCnt - 1'b1;
  end

  assign status.tripSeen  = syncQ[1];
  assign status.blankBusy = (blankCnt != '0);
  assign status.enEdge    = enEdge;
  assign status.cntDone   = (phaseCnt == '0);

  // R6: an enable edge leaves a full blank window behind it
  p_edge_blank_r6: assert property (@(posedge clk) disable iff (!rstN)
    enEdge |=> (blankCnt == BLANK_LOAD));

  // R5: blank counter never exceeds its programmed length
  p_blank_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    blankCnt <= BLANK_LOAD);

endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
  import chop_pkg::*;
#(
  parameter int OFF_CYCLES  = 40,
  parameter int DEAD_CYCLES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         driveEn,
  input  logic         brakeMode,
  input  dp_status_t   status,
  output ctrl_strobe_t strobe,
  output logic         chopOut,
  output logic         fastDecay
);

  localparam int TOTAL_OFF = OFF_CYCLES + DEAD_CYCLES;
  localparam int AGE_W     = $clog2(TOTAL_OFF + 1);

  phase_t state, nextState;
  logic   tripAccept;

  assign tripAccept = status.tripSeen && !status.blankBusy && !status.enEdge
                      && driveEn && !brakeMode;

  always_comb begin
    nextState         = state;
    strobe.cntLoad    = 1'b0;
    strobe.loadPhase  = PH_DRIVE;
    strobe.blankStart = 1'b0;
    if (brakeMode) begin
      nextState = PH_DRIVE;
    end else begin
      unique case (state)
        PH_DRIVE: if (tripAccept) begin
          nextState        = PH_DEAD;
          strobe.cntLoad   = 1'b1;
          strobe.loadPhase = PH_DEAD;
        end
        PH_DEAD: if (status.cntDone) begin
          nextState        = PH_FAST;
          strobe.cntLoad   = 1'b1;
          strobe.loadPhase = PH_FAST;
        end
        PH_FAST: if (status.cntDone) begin
          nextState        = PH_SLOW;
          strobe.cntLoad   = 1'b1;
          strobe.loadPhase = PH_SLOW;
        end
        PH_SLOW: if (status.cntDone) begin
          nextState         = PH_DRIVE;
          strobe.blankStart = 1'b1;
        end
        default: nextState = PH_DRIVE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PH_DRIVE;
    else       state <= nextState;
  end

  assign chopOut   = (state != PH_DRIVE);
  assign fastDecay = (state == PH_FAST);

  // off-time age counter used only by the checks below
  logic [AGE_W-1:0] chkAge;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  chkAge <= '0;
    else if (state == PH_DRIVE) chkAge <= '0;
    else                        chkAge <= chkAge + 1'b1;
  end

  // R10: fast decay only inside the off-time
  p_fast_in_chop_r10: assert property (@(posedge clk) disable iff (!rstN)
    fastDecay |-> chopOut);

  // R8: brake forces the chopper idle on the next cycle
  p_brake_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    brakeMode |=> !chopOut);

  // R9: a chop starts only from a driving bridge
  p_chop_needs_drive_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chopOut) |-> ($past(driveEn) && !$past(brakeMode)));

  // R5 / R6: a chop never starts while blanked or on an enable edge
  p_no_blanked_trip_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chopOut) |-> (!$past(status.blankBusy) && !$past(status.enEdge)));

  // R3: an off-time that is not abandoned lasts its full length
  p_off_length_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(chopOut) && !$past(brakeMode)) |-> ($past(chkAge) == AGE_W'(TOTAL_OFF - 1)));

endmodule

// File: rtl/offtime_chopper.sv
module offtime_chopper
  import chop_pkg::*;
#(
  parameter int OFF_CYCLES   = 40,
  parameter int DEAD_CYCLES  = 2,
  parameter int BLANK_CYCLES = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic tripIn,
  input  logic driveEn,
  input  logic brakeMode,
  output logic chopOut,
  output logic fastDecay
);

  ctrl_strobe_t strobe;
  dp_status_t   status;

  chop_dp #(
    .OFF_CYCLES  (OFF_CYCLES),
    .DEAD_CYCLES (DEAD_CYCLES),
    .BLANK_CYCLES(BLANK_CYCLES)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .tripIn (tripIn),
    .driveEn(driveEn),
    .strobe (strobe),
    .status (status)
  );

  chop_ctrl #(
    .OFF_CYCLES (OFF_CYCLES),
    .DEAD_CYCLES(DEAD_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .driveEn  (driveEn),
    .brakeMode(brakeMode),
    .status   (status),
    .strobe   (strobe),
    .chopOut  (chopOut),
    .fastDecay(fastDecay)
  );

endmodule

// File: tb/offtime_chopper_test.sv
`timescale 1ns/1ps
module offtime_chopper_test;

  localparam int OL = 40;
  localparam int DL = 2;
  localparam int BL = 6;
  localparam int FL = ((13 * OL) / 100 < 1) ? 1 : (13 * OL) / 100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tripIn = 1'b0;
  logic driveEn = 1'b1;
  logic brakeMode = 1'b0;
  logic chopOut, fastDecay;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  offtime_chopper #(.OFF_CYCLES(OL), .DEAD_CYCLES(DL), .BLANK_CYCLES(BL)) uut (
    .clk(clk), .rstN(rstN), .tripIn(tripIn), .driveEn(driveEn),
    .brakeMode(brakeMode), .chopOut(chopOut), .fastDecay(fastDecay)
  );

  typedef struct packed {
    logic       drv;
    logic       brk;
    logic       trip;
    logic [7:0] wt;
    logic       chop;
    logic       fast;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 18;
  // inputs applied at a falling edge, outputs checked wt falling edges later
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 1'b1, 8'(2),        1'b0, 1'b0, 4'd2},  // R2 not yet
    '{1'b1, 1'b0, 1'b1, 8'(1),        1'b1, 1'b0, 4'd2},  // R2 chop, dead
    '{1'b1, 1'b0, 1'b1, 8'(DL),       1'b1, 1'b1, 4'd4},  // R4 fast starts
    '{1'b1, 1'b0, 1'b1, 8'(FL-1),     1'b1, 1'b1, 4'd4},  // R4 last fast
    '{1'b1, 1'b0, 1'b1, 8'(1),        1'b1, 1'b0, 4'd4},  // R4 slow
    '{1'b1, 1'b0, 1'b0, 8'(OL-FL-1),  1'b1, 1'b0, 4'd7},  // R7 not extended
    '{1'b1, 1'b0, 1'b0, 8'(1),        1'b0, 1'b0, 4'd3},  // R3 ends
    '{1'b1, 1'b0, 1'b1, 8'(BL),       1'b0, 1'b0, 4'd5},  // R5 blanked
    '{1'b1, 1'b0, 1'b1, 8'(1),        1'b1, 1'b0, 4'd5},  // R5 re-trip
    '{1'b1, 1'b1, 1'b0, 8'(1),        1'b0, 1'b0, 4'd8},  // R8 abort
    '{1'b1, 1'b1, 1'b1, 8'(10),       1'b0, 1'b0, 4'd8},  // R8 idle
    '{1'b1, 1'b1, 1'b0, 8'(4),        1'b0, 1'b0, 4'd8},  // R8
    '{1'b1, 1'b0, 1'b0, 8'(4),        1'b0, 1'b0, 4'd8},  // R8 release
    '{1'b0, 1'b0, 1'b0, 8'(2),        1'b0, 1'b0, 4'd9},  // R9
    '{1'b0, 1'b0, 1'b1, 8'(6),        1'b0, 1'b0, 4'd9},  // R9 no chop
    '{1'b1, 1'b0, 1'b1, 8'(BL+1),     1'b0, 1'b0, 4'd6},  // R6 edge blanks
    '{1'b1, 1'b0, 1'b1, 8'(1),        1'b1, 1'b0, 4'd6},  // R6 after blank
    '{1'b1, 1'b0, 1'b0, 8'(DL+OL),    1'b0, 1'b0, 4'd3}   // R3
  };

  task automatic check(input string tag, input logic gotC, input logic expC,
                       input logic gotF, input logic expF);
    nChecks++;
    if (gotC !== expC || gotF !== expF) begin
      nFails++;
      $display("FAIL %s: chop=%b fast=%b expected chop=%b fast=%b",
               tag, gotC, gotF, expC, expF);
    end
  endtask

  task automatic check_int(input string tag, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    int dead, fast, tot, guard;
    repeat (3) @(negedge clk);
    check("R1", chopOut, 1'b0, fastDecay, 1'b0);  // R1 during reset
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    check("R1", chopOut, 1'b0, fastDecay, 1'b0);  // R1 idle after reset

    for (int i = 0; i < NV; i++) begin
      driveEn   = VEC[i].drv;
      brakeMode = VEC[i].brk;
      tripIn    = VEC[i].trip;
      repeat (int'(VEC[i].wt)) @(negedge clk);
      check($sformatf("R%0d vec%0d", VEC[i].req, i), chopOut, VEC[i].chop,
            fastDecay, VEC[i].fast);
    end

    // R4 / R3: measure one whole off-time
    tripIn = 1'b1;
    guard = 0;
    while (!chopOut && guard < 100) begin @(negedge clk); guard++; end
    tripIn = 1'b0;
    dead = 0; fast = 0; tot = 0;
    while (chopOut && tot < 500) begin
      if (fastDecay) fast++;
      else if (fast == 0) dead++;
      tot++;
      @(negedge clk);
    end
    check_int("R3 off length", tot, DL + OL);
    check_int("R4 dead length", dead, DL);
    check_int("R4 fast length", fast, FL);

    // R1: reset in the middle of an off-time
    repeat (BL + 2) @(negedge clk);
    tripIn = 1'b1;
    repeat (3 + DL + 1) @(negedge clk);
    check("R4 pre-reset", chopOut, 1'b1, fastDecay, 1'b1);
    rstN = 1'b0;
    #1;
    check("R1 async reset", chopOut, 1'b0, fastDecay, 1'b0);
    tripIn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after reset", chopOut, 1'b0, fastDecay, 1'b0);

    finish_run();
  end

  initial begin
    #100000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run hung, expected completion");
      finish_run();
    end
  end

endmodule